// File: doc/BRIEF.md
# Dual I2C Slave Address Matcher

This block watches a synchronously sampled I2C bus (SCL and SDA) and decides whether the device is addressed by the first byte after each start condition. It detects start and stop conditions and shifts in eight bits on SCL rising edges, MSB first. The upper seven bits are compared against two slave-address registers, a primary and a secondary. The eighth bit is reported as the transfer direction.

Each address register holds a 7-bit address and one format bit. The two format bits form a mode code that decides which address comparisons are live and whether the general-call address is answered. One code value turns off addressing entirely for a non-I2C serial format. After the address byte the block raises an acknowledge request for one bit time when any live comparison matched. Its match flags stay valid until the next start or stop condition. A small write port loads the registers. The secondary register is locked while the module is enabled.

Top module: `i2c_dual_addr_match`

## Requirements
- R1: After reset the primary register holds address 0 with format bit 0, the secondary holds address 0 with format bit 1 (mode {primary,secondary} = {0,1}), and every output is low.
- R2: A start condition (SDA falls while SCL is high) begins a new address capture. A start or a stop condition (SDA rises while SCL is high) clears addr_done_o and all match flags.
- R3: The address byte is taken from eight SCL rising edges, MSB first. Its bit 0 appears on rw_dir_o (1 = read). addr_done_o rises on the second clock edge after the input change that forms the eighth SCL rise.
- R4: In mode {0,0}, a frame address equal to the primary address sets match_pri_o, one equal to the secondary address sets match_sec_o, and general call is answered.
- R5: In mode {0,1}, only the primary comparison and general call are live. The secondary address never matches.
- R6: In mode {1,0}, only the secondary comparison is live. The primary address and general call never match.
- R7: In mode {1,1}, no match flag is ever set and no acknowledge is requested.
- R8: General call is flagged only for the frame 0x00 (address 0, write) when general call is live. A frame address of 0 never sets match_pri_o or match_sec_o.
- R9: ack_req_o rises at the SCL falling edge after the eighth bit and falls at the SCL falling edge after the ninth bit, only when a match flag is set. It stays high for the full ninth bit period.
- R10: A write uses cfg_sel_i = 0 for the primary register and 1 for the secondary, with cfg_wdata_i[7:1] as the address and cfg_wdata_i[0] as the format bit. Secondary writes while module_en_i = 1 are ignored. Primary writes are always taken.
- R11: A repeated start in the middle of a byte, or after a full frame, restarts capture. Bytes after the address byte do not change the flags before the next start or stop.
- R12: While module_en_i = 0 the capture logic stays idle and addr_done_o, the flags and ack_req_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| module_en_i | input | 1 | Module enable; gates capture and locks the secondary register |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 primary, 1 secondary |
| cfg_wdata_i | input | 8 | Write data: [7:1] address, [0] format bit |
| addr_done_o | output | 1 | Address byte captured; flags valid |
| match_pri_o | output | 1 | Primary address matched |
| match_sec_o | output | 1 | Secondary address matched |
| match_gc_o | output | 1 | General call recognised |
| rw_dir_o | output | 1 | Direction bit of the address byte |
| ack_req_o | output | 1 | Acknowledge request for the ninth bit |

## Verification
Every bus condition passes through one sampling register and one state register. Any result therefore appears on the second clock edge after the bench changes SCL or SDA. The bench changes inputs on falling clock edges and samples two falling edges later. It checks this directly on the eighth bit, where addr_done_o is still low one cycle after the change and high one cycle later. The monitor compares the flags and direction with the queued expectation when addr_done_o rises. When addr_done_o falls it checks that ack_req_o was high for exactly three bench bit phases, the time between the two SCL falls the bench drove.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int ADDR_W  = 7;
    localparam int FRAME_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              fmt;
    } slave_cfg_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef enum logic [2:0] {
        CAP_IDLE,
        CAP_SHIFT,
        CAP_ACK_SETUP,
        CAP_ACK_LO,
        CAP_ACK_HI,
        CAP_DONE
    } cap_st_e;

    typedef struct packed {
        logic pri;
        logic sec;
        logic gc;
    } match_t;

endpackage

// File: rtl/i2cm_bus_cond.sv
module i2cm_bus_cond
    import i2cm_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic scl_cur;
        logic sda_cur;
        logic scl_prv;
        logic sda_prv;
    } samp_t;

    samp_t samp_d, samp_q;

    always_comb begin
        samp_d         = samp_q;
        samp_d.scl_cur = scl_i;
        samp_d.sda_cur = sda_i;
        samp_d.scl_prv = samp_q.scl_cur;
        samp_d.sda_prv = samp_q.sda_cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            samp_q <= '1;
        end else begin
            samp_q <= samp_d;
        end
    end

    always_comb begin
        ev_o.start = samp_q.scl_prv & samp_q.scl_cur & samp_q.sda_prv & ~samp_q.sda_cur;
        ev_o.stop  = samp_q.scl_prv & samp_q.scl_cur & ~samp_q.sda_prv & samp_q.sda_cur;
        ev_o.rise  = ~samp_q.scl_prv & samp_q.scl_cur;
        ev_o.fall  = samp_q.scl_prv & ~samp_q.scl_cur;
        ev_o.sda   = samp_q.sda_cur;
    end

endmodule

// File: rtl/i2cm_addr_regs.sv
module i2cm_addr_regs
    import i2cm_pkg::*;
#(
    parameter logic PRI_FMT_RST = 1'b0,
    parameter logic SEC_FMT_RST = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               module_en_i,
    input  logic               we_i,
    input  logic               sel_i,
    input  logic [FRAME_W-1:0] wdata_i,
    output slave_cfg_t         pri_o,
    output slave_cfg_t         sec_o
);

    typedef struct packed {
        slave_cfg_t pri;
        slave_cfg_t sec;
    } regs_t;

    regs_t regs_d, regs_q;
    slave_cfg_t wr_val;

    always_comb begin
        wr_val.addr = wdata_i[FRAME_W-1:1];
        wr_val.fmt  = wdata_i[0];
        regs_d      = regs_q;
        if (we_i) begin
            if (!sel_i) begin
                regs_d.pri = wr_val;
            end else if (!module_en_i) begin
                regs_d.sec = wr_val;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.pri.addr <= '0;
            regs_q.pri.fmt  <= PRI_FMT_RST;
            regs_q.sec.addr <= '0;
            regs_q.sec.fmt  <= SEC_FMT_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pri_o = regs_q.pri;
    assign sec_o = regs_q.sec;

    // R10
    sec_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        module_en_i |=> $stable(regs_q.sec));

endmodule

// File: rtl/i2cm_mode_dec.sv
module i2cm_mode_dec
    import i2cm_pkg::*;
(
    input  logic pri_fmt_i,
    input  logic sec_fmt_i,
    output logic en_pri_o,
    output logic en_sec_o,
    output logic en_gc_o
);

    always_comb begin
        unique case ({pri_fmt_i, sec_fmt_i})
            2'b00: begin en_pri_o = 1'b1; en_sec_o = 1'b1; en_gc_o = 1'b1; end
            2'b01: begin en_pri_o = 1'b1; en_sec_o = 1'b0; en_gc_o = 1'b1; end
            2'b10: begin en_pri_o = 1'b0; en_sec_o = 1'b1; en_gc_o = 1'b0; end
            default: begin en_pri_o = 1'b0; en_sec_o = 1'b0; en_gc_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/i2cm_frame_cap.sv
module i2cm_frame_cap
    import i2cm_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       module_en_i,
    input  bus_ev_t    ev_i,
    input  slave_cfg_t pri_i,
    input  slave_cfg_t sec_i,
    input  logic       en_pri_i,
    input  logic       en_sec_i,
    input  logic       en_gc_i,
    output logic       addr_done_o,
    output match_t     match_o,
    output logic       rw_dir_o,
    output logic       ack_req_o
);

    typedef struct packed {
        cap_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
        match_t             hit;
        logic               rw;
        logic               done;
        logic               ack;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [FRAME_W-1:0] byte_nx;
    logic [ADDR_W-1:0]  frame_addr;
    logic               addr_nz;
    match_t             hit_nx;

    always_comb begin
        byte_nx       = {cap_q.shreg[FRAME_W-2:0], ev_i.sda};
        frame_addr    = byte_nx[FRAME_W-1:1];
        addr_nz       = |frame_addr;
        hit_nx.pri    = en_pri_i & addr_nz & (frame_addr == pri_i.addr);
        hit_nx.sec    = en_sec_i & addr_nz & (frame_addr == sec_i.addr);
        hit_nx.gc     = en_gc_i & (byte_nx == '0);
    end

    always_comb begin
        cap_d = cap_q;
        if (!module_en_i) begin
            cap_d.st   = CAP_IDLE;
            cap_d.cnt  = '0;
            cap_d.hit  = '0;
            cap_d.rw   = 1'b0;
            cap_d.done = 1'b0;
            cap_d.ack  = 1'b0;
        end else if (ev_i.start || ev_i.stop) begin
            cap_d.st   = ev_i.start ? CAP_SHIFT : CAP_IDLE;
            cap_d.cnt  = '0;
            cap_d.hit  = '0;
            cap_d.rw   = 1'b0;
            cap_d.done = 1'b0;
            cap_d.ack  = 1'b0;
        end else begin
            unique case (cap_q.st)
                CAP_SHIFT: begin
                    if (ev_i.rise) begin
                        cap_d.shreg = byte_nx;
                        if (cap_q.cnt == CNT_W'(FRAME_W - 1)) begin
                            cap_d.hit  = hit_nx;
                            cap_d.rw   = byte_nx[0];
                            cap_d.done = 1'b1;
                            cap_d.st   = CAP_ACK_SETUP;
                        end else begin
                            cap_d.cnt = cap_q.cnt + 1'b1;
                        end
                    end
                end
                CAP_ACK_SETUP: begin
                    if (ev_i.fall) begin
                        cap_d.ack = |cap_q.hit;
                        cap_d.st  = CAP_ACK_LO;
                    end
                end
                CAP_ACK_LO: begin
                    if (ev_i.rise) begin
                        cap_d.st = CAP_ACK_HI;
                    end
                end
                CAP_ACK_HI: begin
                    if (ev_i.fall) begin
                        cap_d.ack = 1'b0;
                        cap_d.st  = CAP_DONE;
                    end
                end
                default: cap_d.st = cap_q.st;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q.st    <= CAP_IDLE;
            cap_q.cnt   <= '0;
            cap_q.shreg <= '0;
            cap_q.hit   <= '0;
            cap_q.rw    <= 1'b0;
            cap_q.done  <= 1'b0;
            cap_q.ack   <= 1'b0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_done_o = cap_q.done;
    assign match_o     = cap_q.hit;
    assign rw_dir_o    = cap_q.rw;
    assign ack_req_o   = cap_q.ack;

    // R9
    ack_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_q.ack |-> (cap_q.done && (|cap_q.hit)));

    // R2
    start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (module_en_i && ev_i.start) |=> (!cap_q.done && cap_q.hit == '0));

    // R8
    gc_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_q.hit.gc |-> !cap_q.rw);

    // R7
    sync_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(cap_q.done) && $past(pri_i.fmt && sec_i.fmt)) |-> (cap_q.hit == '0));

    // R12
    disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !module_en_i |=> (!cap_q.done && !cap_q.ack));

endmodule

// File: rtl/i2c_dual_addr_match.sv
module i2c_dual_addr_match
    import i2cm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               module_en_i,
    input  logic               cfg_we_i,
    input  logic               cfg_sel_i,
    input  logic [FRAME_W-1:0] cfg_wdata_i,
    output logic               addr_done_o,
    output logic               match_pri_o,
    output logic               match_sec_o,
    output logic               match_gc_o,
    output logic               rw_dir_o,
    output logic               ack_req_o
);

    bus_ev_t    ev;
    slave_cfg_t pri_cfg;
    slave_cfg_t sec_cfg;
    logic       en_pri;
    logic       en_sec;
    logic       en_gc;
    match_t     hit;

    i2cm_bus_cond u_cond (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .ev_o   (ev)
    );

    i2cm_addr_regs #(
        .PRI_FMT_RST (1'b0),
        .SEC_FMT_RST (1'b1)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .module_en_i (module_en_i),
        .we_i        (cfg_we_i),
        .sel_i       (cfg_sel_i),
        .wdata_i     (cfg_wdata_i),
        .pri_o       (pri_cfg),
        .sec_o       (sec_cfg)
    );

    i2cm_mode_dec u_mode (
        .pri_fmt_i (pri_cfg.fmt),
        .sec_fmt_i (sec_cfg.fmt),
        .en_pri_o  (en_pri),
        .en_sec_o  (en_sec),
        .en_gc_o   (en_gc)
    );

    i2cm_frame_cap u_cap (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .module_en_i (module_en_i),
        .ev_i        (ev),
        .pri_i       (pri_cfg),
        .sec_i       (sec_cfg),
        .en_pri_i    (en_pri),
        .en_sec_i    (en_sec),
        .en_gc_i     (en_gc),
        .addr_done_o (addr_done_o),
        .match_o     (hit),
        .rw_dir_o    (rw_dir_o),
        .ack_req_o   (ack_req_o)
    );

    assign match_pri_o = hit.pri;
    assign match_sec_o = hit.sec;
    assign match_gc_o  = hit.gc;

endmodule

// File: tb/i2c_dual_addr_match_tb_top.sv
module i2c_dual_addr_match_tb_top;

    localparam int W = 4;

    typedef struct {
        bit    pri;
        bit    sec;
        bit    gc;
        bit    rw;
        bit    ack;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       en = 1'b0;
    logic       we = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] wdata = '0;
    logic       addr_done, m_pri, m_sec, m_gc, rw_dir, ack_req;

    int  tests = 0;
    int  fails = 0;
    bit  done_flag = 1'b0;
    exp_t sb[$];

    bit [6:0] mp_addr = 7'd0;
    bit       mp_fmt  = 1'b0;
    bit [6:0] ms_addr = 7'd0;
    bit       ms_fmt  = 1'b1;

    always #4 clk = ~clk;

    i2c_dual_addr_match dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .scl_i       (scl),
        .sda_i       (sda),
        .module_en_i (en),
        .cfg_we_i    (we),
        .cfg_sel_i   (sel),
        .cfg_wdata_i (wdata),
        .addr_done_o (addr_done),
        .match_pri_o (m_pri),
        .match_sec_o (m_sec),
        .match_gc_o  (m_gc),
        .rw_dir_o    (rw_dir),
        .ack_req_o   (ack_req)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic phase();
        repeat (W) @(negedge clk);
    endtask

    task automatic wr_reg(bit s, bit [6:0] a, bit f);
        @(negedge clk);
        we = 1'b1; sel = s; wdata = {a, f};
        @(negedge clk);
        we = 1'b0;
        if (!s) begin mp_addr = a; mp_fmt = f; end
        else if (!en) begin ms_addr = a; ms_fmt = f; end
    endtask

    task automatic set_en(bit v);
        @(negedge clk);
        en = v;
        @(negedge clk);
    endtask

    function automatic exp_t model(bit [7:0] f, string tag);
        exp_t e;
        bit [6:0] a = f[7:1];
        bit lp, ls, lg;
        case ({mp_fmt, ms_fmt})
            2'b00:   begin lp = 1; ls = 1; lg = 1; end
            2'b01:   begin lp = 1; ls = 0; lg = 1; end
            2'b10:   begin lp = 0; ls = 1; lg = 0; end
            default: begin lp = 0; ls = 0; lg = 0; end
        endcase
        e.pri = lp && a != 0 && a == mp_addr;
        e.sec = ls && a != 0 && a == ms_addr;
        e.gc  = lg && f == 8'h00;
        e.rw  = f[0];
        e.ack = e.pri || e.sec || e.gc;
        e.tag = tag;
        return e;
    endfunction

    task automatic bus_start();
        if (!scl) begin
            sda = 1'b1; phase();
            scl = 1'b1; phase();
        end
        sda = 1'b0; phase();
        scl = 1'b0; phase();
    endtask

    task automatic bus_stop();
        sda = 1'b0; phase();
        scl = 1'b1; phase();
        sda = 1'b1; phase();
    endtask

    task automatic send_bits(bit [7:0] b, int n, bit lat);
        for (int i = 7; i > 7 - n; i--) begin
            sda = b[i]; phase();
            scl = 1'b1;
            if (lat && i == 0) begin
                @(negedge clk);
                check(addr_done == 1'b0, "R3", "addr_done one cycle after 8th rise", addr_done, 0);
                @(negedge clk);
                check(addr_done == 1'b1, "R3", "addr_done two cycles after 8th rise", addr_done, 1);
                repeat (W - 2) @(negedge clk);
            end else begin
                phase();
            end
            scl = 1'b0; phase();
        end
    endtask

    task automatic ninth_clock();
        sda = 1'b0; phase();
        scl = 1'b1; phase();
        scl = 1'b0; phase();
    endtask

    task automatic frame(bit [7:0] f, bit stop, string tag);
        if (en) sb.push_back(model(f, tag));
        bus_start();
        send_bits(f, 8, en);
        ninth_clock();
        if (stop) bus_stop();
    endtask

    initial begin : monitor
        bit   prev = 1'b0;
        bit   have = 1'b0;
        int   acklen = 0;
        exp_t cur;
        forever begin
            @(negedge clk);
            if (addr_done && !prev) begin
                acklen = 0;
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected addr_done", 1, 0);
                end else begin
                    cur  = sb.pop_front();
                    have = 1'b1;
                    check(m_pri == cur.pri, cur.tag, "match_pri", m_pri, cur.pri);
                    check(m_sec == cur.sec, cur.tag, "match_sec", m_sec, cur.sec);
                    check(m_gc == cur.gc, cur.tag, "match_gc", m_gc, cur.gc);
                    check(rw_dir == cur.rw, "R3", "rw_dir", rw_dir, cur.rw);
                end
            end
            if (addr_done && ack_req) acklen++;
            if (!addr_done && prev && have) begin
                // R9: ack spans from the 8th SCL fall to the 9th, 3 bench phases
                check(acklen == (cur.ack ? 3 * W : 0), "R9", "ack_req length", acklen, cur.ack ? 3 * W : 0);
                check({m_pri, m_sec, m_gc, ack_req} == 4'b0, "R2", "flags cleared", {m_pri, m_sec, m_gc, ack_req}, 0);
                have = 1'b0;
            end
            prev = addr_done;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R1: outputs low during and after reset
        check({addr_done, m_pri, m_sec, m_gc, rw_dir, ack_req} == 6'b0, "R1", "outputs in reset",
              {addr_done, m_pri, m_sec, m_gc, rw_dir, ack_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({addr_done, m_pri, m_sec, m_gc, rw_dir, ack_req} == 6'b0, "R1", "outputs after reset",
              {addr_done, m_pri, m_sec, m_gc, rw_dir, ack_req}, 0);

        // R1: reset mode {0,1}, both addresses 0
        set_en(1);
        frame(8'h00, 1, "R1");
        frame(8'h01, 1, "R8");
        wr_reg(0, 7'h2A, 0);
        frame(8'h54, 1, "R1");

        // R4: mode {0,0}
        set_en(0);
        wr_reg(1, 7'h55, 0);
        set_en(1);
        frame(8'h54, 1, "R4");
        frame(8'hAB, 1, "R4");
        frame(8'h00, 1, "R4");
        frame(8'h26, 1, "R4");

        // R10: secondary write ignored while enabled
        wr_reg(1, 7'h33, 1);
        frame(8'h66, 1, "R10");
        frame(8'hAA, 1, "R10");

        // R5: mode {0,1}
        set_en(0);
        wr_reg(1, 7'h55, 1);
        set_en(1);
        frame(8'hAA, 1, "R5");
        frame(8'h54, 1, "R5");
        frame(8'h00, 1, "R5");

        // R6: mode {1,0}; primary write accepted while enabled (R10)
        wr_reg(0, 7'h2A, 1);
        set_en(0);
        wr_reg(1, 7'h55, 0);
        set_en(1);
        frame(8'h54, 1, "R6");
        frame(8'hAA, 1, "R6");
        frame(8'h00, 1, "R6");

        // R7: mode {1,1}
        set_en(0);
        wr_reg(1, 7'h55, 1);
        set_en(1);
        frame(8'h54, 1, "R7");
        frame(8'hAA, 1, "R7");
        frame(8'h00, 1, "R7");

        // R11: back to mode {0,0}; repeated starts
        wr_reg(0, 7'h2A, 0);
        set_en(0);
        wr_reg(1, 7'h55, 0);
        set_en(1);
        bus_start();
        send_bits(8'h26, 4, 0);
        frame(8'h54, 1, "R11");
        frame(8'hAA, 0, "R11");
        frame(8'h54, 1, "R11");

        // R11: byte after the address does not alter flags
        frame(8'h26, 0, "R11");
        send_bits(8'h54, 8, 0);
        ninth_clock();
        check(addr_done == 1'b1, "R11", "addr_done held over data byte", addr_done, 1);
        check(m_pri == 1'b0, "R11", "match_pri after data byte", m_pri, 0);
        check(ack_req == 1'b0, "R11", "ack_req after data byte", ack_req, 0);
        bus_stop();

        // R12: disabled module stays idle
        set_en(0);
        frame(8'h54, 1, "R12");
        check(addr_done == 1'b0, "R12", "addr_done while disabled", addr_done, 0);
        check(m_pri == 1'b0, "R12", "match_pri while disabled", m_pri, 0);

        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R3", "pending expectations", sb.size(), 0);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule